// File: doc/BRIEF.md
# Dual-Channel Indirect Register Access Controller

This block sits between a host bus and a two-channel serial controller. The host sees four byte-wide ports: a command port and a data port for each of channel A and channel B. Registers behind the command ports are reached indirectly. One register pointer, shared by both channels, names one of sixteen registers. A first command-port write loads the pointer. The next command-port access, read or write, reaches the named register. After that access the pointer falls back to zero by itself.

Two pointer values are intercepted before any channel sees them. Index 2 is an interrupt vector that both channels share. Index 9 is the master interrupt control register. A write to index 9 carries a reset command in its top two bits, and that command can soft-reset one channel or hard-reset the whole controller. All other indices reach a per-channel register bank. Data-port writes hand a byte to that channel's transmit path, and data-port reads pop a byte from its receive path. The pointer is not touched by data-port traffic.

Top module: `dual_chan_regif`

## Requirements
- R1: After `rst_n` is released the pointer is 0, the vector register is 0x00, `irq_ctrl` is 0xC0, and every bank register of both channels reads 0x00.
- R2: Port offsets are 0 = channel A command, 1 = channel A data, 2 = channel B command, 3 = channel B data. When the pointer is 0, a command-port write loads byte bits 2:0 into pointer bits 2:0. It sets pointer bit 3 exactly when byte bits 5:3 equal 3'b001. Bits 7:6 are ignored.
- R3: When the pointer is nonzero, a command-port write stores the byte in the selected register, and the pointer is 0 for the next access.
- R4: A command-port read returns the selected register of that port's channel. With pointer 0 it returns register 0. The pointer is 0 afterwards. The pointer is shared, so it may be loaded through one channel's port and used through the other.
- R5: Pointer 2 selects one vector register. It is written from either command port and read back identically from either one.
- R6: Pointer 9 selects the master control register, which is readable from either command port and always driven on `irq_ctrl`. A write with bits 7:6 = 00 replaces bits 5:0 and keeps bits 7:6.
- R7: A write to pointer 9 with bits 7:6 = 01 resets channel B, and 10 resets channel A. Either one keeps control bits 7:6, clears bit 5, and stores byte bits 4:0. The reset clears bank registers 0 to 7 of that channel only and keeps registers 8 to 15.
- R8: A write to pointer 9 with bits 7:6 = 11 makes the control register {2'b11, byte bits 5:2, 2'b00} and clears every bank register of both channels.
- R9: A data-port write raises `tx_valid` for that channel in the same cycle, with `tx_byte` equal to the written byte. A data-port read returns that channel's receive byte and raises its `rx_pop` bit (bit 0 = A, bit 1 = B). Data-port accesses leave the pointer unchanged.
- R10: An access to offsets 4 to 7 has no effect. It changes no register and no pointer, raises no strobe, and reads 0x00.
- R11: When `bus_wr` and `bus_rd` are high together, only the write happens. No `rx_pop` is raised and the pointer changes only as the write requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up full reset) |
| bus_addr | input | 3 | Port offset |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational during the read cycle |
| tx_valid | output | 2 | Transmit byte strobe per channel (bit 0 = A) |
| tx_byte | output | 8 | Byte offered to the transmit path |
| rx_byte_a | input | 8 | Receive byte from channel A |
| rx_byte_b | input | 8 | Receive byte from channel B |
| rx_pop | output | 2 | Receive byte taken, per channel (bit 0 = A) |
| irq_ctrl | output | 8 | Master interrupt control register contents |

## Verification
The bench sweeps every register index through both command ports, against a model of the banks, the vector and the control register. It targets the pointer return to zero. If the pointer were left set, the second read of a pair would return the previous register rather than register 0. It drives point-high bytes with junk in bits 7:6 and near-miss codes in bits 5:3. A decoder that looked at the wrong bits would land on a different register. Each of the four reset codes is applied. A reset steered to the wrong channel, or one that cleared the kept upper half, shows up as mismatches in the readback sweep. A wrong mask on the control register shows up on `irq_ctrl`. Data-port, undefined-offset and write-plus-read accesses are placed between a pointer load and its use, so a design that let them consume the pointer would read the wrong register.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

   // Reset command carried in the top two bits of a master-control write
   typedef enum logic [1:0] {
      RCMD_NONE = 2'b00,
      RCMD_CHB  = 2'b01,
      RCMD_CHA  = 2'b10,
      RCMD_ALL  = 2'b11
   } rst_cmd_e;

   localparam int CH_A   = 0;
   localparam int CH_B   = 1;
   localparam int NUM_CH = 2;

   // Port offsets: bit 1 picks the channel, bit 0 picks data over command
   localparam int OFS_CH_BIT   = 1;
   localparam int OFS_DATA_BIT = 0;
   localparam int OFS_COUNT    = 4;

endpackage

// File: rtl/dcr_ptr.sv
module dcr_ptr #(
   parameter int          PTR_W   = 4,
   parameter logic [2:0]  PH_CODE = 3'b001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic               cmd_rd,
   input  logic               side_acc,
   input  logic [PTR_W+1:0]   cmd_byte,
   output logic [PTR_W-1:0]   ptr
);
   localparam int LOW_W = PTR_W - 1;

   initial begin
      assert (PTR_W >= 2) else $error("dcr_ptr: PTR_W must be at least 2");
   end

   logic             ph_hit;
   logic [PTR_W-1:0] ptr_load;
   logic             ptr_zero;

   assign ptr_zero = (ptr == '0);
   assign ph_hit   = (cmd_byte[LOW_W+2:LOW_W] == PH_CODE);
   assign ptr_load = {ph_hit, cmd_byte[LOW_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (cmd_wr) begin
         ptr <= ptr_zero ? ptr_load : '0;
      end else if (cmd_rd) begin
         ptr <= '0;
      end
   end

   // R3: a register write consumes the pointer
   a_r3_ptr_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && ptr != '0) |=> (ptr == '0));

   // R4: a command read consumes the pointer
   a_r4_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && !cmd_wr) |=> (ptr == '0));

   // R2: point-high code lifts the pointer into the upper bank
   a_r2_point_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && ptr == '0 && cmd_byte[LOW_W+2:LOW_W] == PH_CODE) |=> ptr[PTR_W-1]);

   // R9: data or undefined traffic leaves the pointer alone
   a_r9_side_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (side_acc && !cmd_wr && !cmd_rd) |=> $stable(ptr));

endmodule

// File: rtl/dcr_shared.sv
module dcr_shared
   import dcr_pkg::*;
#(
   parameter int            DATA_W    = 8,
   parameter logic [DATA_W-1:0] MIC_INIT = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_we,
   input  logic              mic_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] vec_q,
   output logic [DATA_W-1:0] mic_q,
   output logic [NUM_CH-1:0] soft_rst,
   output logic              hard_rst
);
   localparam int TOP = DATA_W - 1;
   localparam int MID = DATA_W - 3;

   initial begin
      assert (DATA_W >= 6) else $error("dcr_shared: DATA_W must be at least 6");
   end

   rst_cmd_e cmd;
   logic [DATA_W-1:0] mic_next;

   assign cmd = rst_cmd_e'(wdata[TOP:TOP-1]);

   always_comb begin
      soft_rst = '0;
      hard_rst = 1'b0;
      mic_next = mic_q;
      if (mic_we) begin
         unique case (cmd)
            RCMD_NONE: mic_next = {mic_q[TOP:TOP-1], wdata[MID:0]};
            RCMD_CHB: begin
               soft_rst[CH_B] = 1'b1;
               mic_next = {mic_q[TOP:TOP-1], 1'b0, wdata[MID-1:0]};
            end
            RCMD_CHA: begin
               soft_rst[CH_A] = 1'b1;
               mic_next = {mic_q[TOP:TOP-1], 1'b0, wdata[MID-1:0]};
            end
            RCMD_ALL: begin
               hard_rst = 1'b1;
               mic_next = {2'b11, wdata[MID:2], 2'b00};
            end
            default: mic_next = mic_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q <= '0;
         mic_q <= MIC_INIT;
      end else begin
         if (vec_we) vec_q <= wdata;
         mic_q <= mic_next;
      end
   end

   // R8: a full reset command forces the top pair high and the low pair low
   a_r8_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (mic_we && wdata[TOP:TOP-1] == 2'b11) |=> (mic_q[TOP:TOP-1] == 2'b11 && mic_q[1:0] == 2'b00));

   // R7: a single-channel reset clears bit 5 and keeps the top pair
   a_r7_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (mic_we && (wdata[TOP:TOP-1] == 2'b01 || wdata[TOP:TOP-1] == 2'b10))
      |=> (!mic_q[MID] && mic_q[TOP:TOP-1] == $past(mic_q[TOP:TOP-1])));

   // R6: control register changes only when written
   a_r6_mic_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mic_we |=> $stable(mic_q));

   // R5: vector changes only when written
   a_r5_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_we |=> $stable(vec_q));

endmodule

// File: rtl/dcr_chan_bank.sv
module dcr_chan_bank #(
   parameter int DATA_W         = 8,
   parameter int PTR_W          = 4,
   parameter int SOFT_CLR_BELOW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              soft_rst,
   input  logic              hard_rst,
   output logic [DATA_W-1:0] rdata
);
   localparam int NREG = 2 ** PTR_W;

   initial begin
      assert (SOFT_CLR_BELOW >= 0 && SOFT_CLR_BELOW <= NREG)
         else $error("dcr_chan_bank: SOFT_CLR_BELOW out of range");
   end

   logic [DATA_W-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i < SOFT_CLR_BELOW) begin : g_soft
         always_ff @(posedge clk) begin
            if (!rst_n || hard_rst || soft_rst) begin
               regs[i] <= '0;
            end else if (wr_en && idx == PTR_W'(i)) begin
               regs[i] <= wdata;
            end
         end
         // R7: soft reset clears the lower half
         a_r7_low_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> (regs[i] == '0));
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (!rst_n || hard_rst) begin
               regs[i] <= '0;
            end else if (wr_en && idx == PTR_W'(i)) begin
               regs[i] <= wdata;
            end
         end
         // R7: soft reset keeps the upper half
         a_r7_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (soft_rst && !hard_rst && !wr_en) |=> $stable(regs[i]));
      end
      // R8: hard reset clears every register
      a_r8_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         hard_rst |=> (regs[i] == '0));
   end

   assign rdata = regs[idx];

endmodule

// File: rtl/dual_chan_regif.sv
module dual_chan_regif
   import dcr_pkg::*;
#(
   parameter int            ADDR_W         = 3,
   parameter int            DATA_W         = 8,
   parameter int            PTR_W          = 4,
   parameter int            VEC_IDX        = 2,
   parameter int            MIC_IDX        = 9,
   parameter logic [2:0]    PH_CODE        = 3'b001,
   parameter int            SOFT_CLR_BELOW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] tx_valid,
   output logic [DATA_W-1:0] tx_byte,
   input  logic [DATA_W-1:0] rx_byte_a,
   input  logic [DATA_W-1:0] rx_byte_b,
   output logic [NUM_CH-1:0] rx_pop,
   output logic [DATA_W-1:0] irq_ctrl
);
   localparam int NREG = 2 ** PTR_W;

   initial begin
      assert (ADDR_W >= 2) else $error("dual_chan_regif: ADDR_W must cover four ports");
      assert (DATA_W >= PTR_W + 2) else $error("dual_chan_regif: DATA_W too narrow for pointer load");
      assert (VEC_IDX > 0 && VEC_IDX < NREG) else $error("dual_chan_regif: VEC_IDX out of range");
      assert (MIC_IDX > 0 && MIC_IDX < NREG) else $error("dual_chan_regif: MIC_IDX out of range");
      assert (VEC_IDX != MIC_IDX) else $error("dual_chan_regif: shared indices collide");
   end

   // ---------------- port decode ----------------
   logic              addr_ok;
   logic              acc_ch;
   logic              acc_data;
   logic              wr_go, rd_go;
   logic              cmd_wr, cmd_rd, dat_wr, dat_rd;
   logic              side_acc;

   assign addr_ok  = (bus_addr < ADDR_W'(OFS_COUNT));
   assign acc_ch   = bus_addr[OFS_CH_BIT];
   assign acc_data = bus_addr[OFS_DATA_BIT];
   assign wr_go    = bus_wr;
   assign rd_go    = bus_rd & ~bus_wr;
   assign cmd_wr   = wr_go & addr_ok & ~acc_data;
   assign cmd_rd   = rd_go & addr_ok & ~acc_data;
   assign dat_wr   = wr_go & addr_ok &  acc_data;
   assign dat_rd   = rd_go & addr_ok &  acc_data;
   assign side_acc = (bus_wr | bus_rd) & ~(cmd_wr | cmd_rd);

   // ---------------- pointer ----------------
   logic [PTR_W-1:0] ptr;

   dcr_ptr #(.PTR_W(PTR_W), .PH_CODE(PH_CODE)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_rd   (cmd_rd),
      .side_acc (side_acc),
      .cmd_byte (bus_wdata[PTR_W+1:0]),
      .ptr      (ptr)
   );

   logic ptr_set, sel_vec, sel_mic, reg_wr;
   assign ptr_set = (ptr != '0);
   assign sel_vec = (ptr == PTR_W'(VEC_IDX));
   assign sel_mic = (ptr == PTR_W'(MIC_IDX));
   assign reg_wr  = cmd_wr & ptr_set;

   // ---------------- shared registers ----------------
   logic [DATA_W-1:0] vec_q, mic_q;
   logic [NUM_CH-1:0] soft_rst;
   logic              hard_rst;

   dcr_shared #(.DATA_W(DATA_W), .MIC_INIT(DATA_W'(8'hC0))) u_shared (
      .clk      (clk),
      .rst_n    (rst_n),
      .vec_we   (reg_wr & sel_vec),
      .mic_we   (reg_wr & sel_mic),
      .wdata    (bus_wdata),
      .vec_q    (vec_q),
      .mic_q    (mic_q),
      .soft_rst (soft_rst),
      .hard_rst (hard_rst)
   );

   assign irq_ctrl = mic_q;

   // ---------------- per-channel banks ----------------
   logic [DATA_W-1:0] bank_rd [NUM_CH];
   logic [DATA_W-1:0] rx_sel  [NUM_CH];

   assign rx_sel[CH_A] = rx_byte_a;
   assign rx_sel[CH_B] = rx_byte_b;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic bank_we;
      assign bank_we     = reg_wr & ~sel_vec & ~sel_mic & (acc_ch == 1'(c));
      assign tx_valid[c] = dat_wr & (acc_ch == 1'(c));
      assign rx_pop[c]   = dat_rd & (acc_ch == 1'(c));

      dcr_chan_bank #(
         .DATA_W         (DATA_W),
         .PTR_W          (PTR_W),
         .SOFT_CLR_BELOW (SOFT_CLR_BELOW)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bank_we),
         .idx      (ptr),
         .wdata    (bus_wdata),
         .soft_rst (soft_rst[c]),
         .hard_rst (hard_rst),
         .rdata    (bank_rd[c])
      );
   end

   assign tx_byte = bus_wdata;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (cmd_rd) begin
         if (sel_vec)      bus_rdata = vec_q;
         else if (sel_mic) bus_rdata = mic_q;
         else              bus_rdata = bank_rd[acc_ch];
      end else if (dat_rd) begin
         bus_rdata = rx_sel[acc_ch];
      end
   end

   // R10: undefined offsets raise nothing and read zero
   a_r10_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && bus_addr >= ADDR_W'(OFS_COUNT))
      |-> (bus_rdata == '0 && tx_valid == '0 && rx_pop == '0));

   // R10: undefined offsets leave the pointer and shared state unchanged
   a_r10_undef_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && bus_addr >= ADDR_W'(OFS_COUNT))
      |=> ($stable(ptr) && $stable(irq_ctrl)));

   // R11: a write beside a read never pops receive data
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_rd) |-> (rx_pop == '0));

   // R9: at most one strobe of each kind per cycle
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_valid) && $onehot0(rx_pop));

endmodule

// File: tb/dual_chan_regif_test.sv
module dual_chan_regif_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] tx_valid;
   logic [7:0] tx_byte;
   logic [7:0] rx_byte_a = 8'h00;
   logic [7:0] rx_byte_b = 8'h00;
   logic [1:0] rx_pop;
   logic [7:0] irq_ctrl;

   dual_chan_regif uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_byte_a(rx_byte_a),
      .rx_byte_b(rx_byte_b), .rx_pop(rx_pop), .irq_ctrl(irq_ctrl)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] bank_m [2][16];
   logic [7:0] vec_m;
   logic [7:0] mic_m;

   logic [1:0] last_tx_valid;
   logic [7:0] last_tx_byte;
   logic [1:0] last_pop;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] cmd_ofs(input int ch);
      return (ch == 0) ? 3'd0 : 3'd2;
   endfunction

   function automatic logic [2:0] dat_ofs(input int ch);
      return (ch == 0) ? 3'd1 : 3'd3;
   endfunction

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      #1;
      last_tx_valid = tx_valid;
      last_tx_byte  = tx_byte;
      last_pop      = rx_pop;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      last_pop = rx_pop;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_ptr(input int ch, input int r);
      logic [7:0] v;
      v = {2'b00, (r >= 8) ? 3'b001 : 3'b000, 3'(r)};
      bus_write(cmd_ofs(ch), v);
   endtask

   function automatic logic [7:0] exp_reg(input int ch, input int r);
      if (r == 2) return vec_m;
      if (r == 9) return mic_m;
      return bank_m[ch][r];
   endfunction

   function automatic void mdl_write(input int ch, input int r, input logic [7:0] v);
      if (r == 2) begin
         vec_m = v;
      end else if (r == 9) begin
         case (v[7:6])
            2'b00: mic_m = {mic_m[7:6], v[5:0]};
            2'b01: begin
               mic_m = {mic_m[7:6], 1'b0, v[4:0]};
               for (int k = 0; k < 8; k++) bank_m[1][k] = 8'h00;
            end
            2'b10: begin
               mic_m = {mic_m[7:6], 1'b0, v[4:0]};
               for (int k = 0; k < 8; k++) bank_m[0][k] = 8'h00;
            end
            default: begin
               mic_m = {2'b11, v[5:2], 2'b00};
               for (int c = 0; c < 2; c++)
                  for (int k = 0; k < 16; k++) bank_m[c][k] = 8'h00;
            end
         endcase
      end else begin
         bank_m[ch][r] = v;
      end
   endfunction

   task automatic reg_write(input int ch, input int r, input logic [7:0] v);
      set_ptr(ch, r);
      bus_write(cmd_ofs(ch), v);
      mdl_write(ch, r, v);
   endtask

   task automatic sweep(input string req);
      logic [7:0] d;
      for (int ch = 0; ch < 2; ch++) begin
         for (int r = 0; r < 16; r++) begin
            set_ptr(ch, r);
            bus_read(cmd_ofs(ch), d);
            check($sformatf("%s ch%0d reg%0d", req, ch, r), d, exp_reg(ch, r));
         end
      end
      check({req, " irq_ctrl"}, irq_ctrl, mic_m);
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [7:0] d;
      for (int c = 0; c < 2; c++)
         for (int k = 0; k < 16; k++) bank_m[c][k] = 8'h00;
      vec_m = 8'h00;
      mic_m = 8'hC0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 irq_ctrl after reset", irq_ctrl, 8'hC0);
      sweep("R1 reset readback");

      // R3 / R5 / R6: exhaustive write of every index through both ports
      for (int ch = 0; ch < 2; ch++) begin
         for (int r = 1; r < 16; r++) begin
            logic [7:0] v;
            v = 8'((r * 37 + ch * 91 + 5) & 255);
            if (r == 9) v = v & 8'h3F;
            reg_write(ch, r, v);
         end
      end
      sweep("R3 R5 R6 write sweep");

      // R5: vector written via B reads same via A
      reg_write(1, 2, 8'hA5);
      set_ptr(0, 2);
      bus_read(cmd_ofs(0), d);
      check("R5 vector cross-port", d, 8'hA5);

      // R6: write code 00 keeps top bits
      reg_write(0, 9, 8'h15);
      check("R6 control keep top", irq_ctrl, 8'hD5);

      // R2: junk in bits 7:6 ignored, point-high picks upper bank
      bus_write(cmd_ofs(0), 8'hCB);
      bus_read(cmd_ofs(0), d);
      check("R2 point-high with junk top bits", d, bank_m[0][11]);
      // R2: near-miss code 010 does not lift
      bus_write(cmd_ofs(1), 8'h13);
      bus_read(cmd_ofs(1), d);
      check("R2 code 010 stays low", d, bank_m[1][3]);
      // R2: code 101 does not lift
      bus_write(cmd_ofs(1), 8'h2E);
      bus_read(cmd_ofs(1), d);
      check("R2 code 101 stays low", d, bank_m[1][6]);

      // R4: read consumes pointer; second read returns register 0
      set_ptr(0, 5);
      bus_read(cmd_ofs(0), d);
      check("R4 selected read", d, bank_m[0][5]);
      bus_read(cmd_ofs(0), d);
      check("R4 pointer back to 0", d, bank_m[0][0]);
      // R4: load via A, read via B
      set_ptr(0, 12);
      bus_read(cmd_ofs(1), d);
      check("R4 cross-port read", d, bank_m[1][12]);

      // R3: after a register write, next command write loads the pointer
      reg_write(1, 4, 8'h3C);
      bus_write(cmd_ofs(1), 8'h07);
      bus_read(cmd_ofs(1), d);
      check("R3 pointer zero after write", d, bank_m[1][7]);

      // R9: data-port traffic
      bus_write(dat_ofs(0), 8'h5A);
      check("R9 tx_valid A", {6'd0, last_tx_valid}, 8'h01);
      check("R9 tx_byte A", last_tx_byte, 8'h5A);
      bus_write(dat_ofs(1), 8'hC3);
      check("R9 tx_valid B", {6'd0, last_tx_valid}, 8'h02);
      check("R9 tx_byte B", last_tx_byte, 8'hC3);
      rx_byte_a = 8'h77; rx_byte_b = 8'h88;
      bus_read(dat_ofs(0), d);
      check("R9 rx byte A", d, 8'h77);
      check("R9 rx_pop A", {6'd0, last_pop}, 8'h01);
      bus_read(dat_ofs(1), d);
      check("R9 rx byte B", d, 8'h88);
      check("R9 rx_pop B", {6'd0, last_pop}, 8'h02);
      set_ptr(1, 13);
      bus_write(dat_ofs(0), 8'h11);
      bus_read(dat_ofs(1), d);
      bus_read(cmd_ofs(1), d);
      check("R9 pointer kept across data access", d, bank_m[1][13]);

      // R10: undefined offsets
      set_ptr(0, 3);
      for (int a = 4; a < 8; a++) begin
         bus_write(3'(a), 8'hFF);
         check($sformatf("R10 no tx at ofs %0d", a), {6'd0, last_tx_valid}, 8'h00);
         bus_read(3'(a), d);
         check($sformatf("R10 read zero at ofs %0d", a), d, 8'h00);
         check($sformatf("R10 no pop at ofs %0d", a), {6'd0, last_pop}, 8'h00);
      end
      bus_read(cmd_ofs(0), d);
      check("R10 pointer survives undefined access", d, bank_m[0][3]);
      check("R10 control untouched", irq_ctrl, mic_m);

      // R11: write and read together on data port A
      @(negedge clk);
      bus_addr = dat_ofs(0); bus_wdata = 8'h42; bus_wr = 1'b1; bus_rd = 1'b1;
      #1;
      check("R11 no pop on simultaneous", {6'd0, rx_pop}, 8'h00);
      check("R11 write goes through", {6'd0, tx_valid}, 8'h01);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      // R11: simultaneous on command port acts as pointer load
      @(negedge clk);
      bus_addr = cmd_ofs(1); bus_wdata = 8'h0E; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      bus_read(cmd_ofs(1), d);
      check("R11 simultaneous cmd loads pointer", d, bank_m[1][14]);

      // R7: channel B reset
      reg_write(0, 9, 8'h7F);
      check("R7 control after B reset", irq_ctrl, mic_m);
      sweep("R7 after B reset");
      // refill lower halves, then channel A reset
      for (int ch = 0; ch < 2; ch++)
         for (int r = 1; r < 8; r++)
            if (r != 2) reg_write(ch, r, 8'(8'h90 + ch * 16 + r));
      reg_write(1, 9, 8'hA0);
      check("R7 control after A reset", irq_ctrl, mic_m);
      sweep("R7 after A reset");

      // R8: full reset command
      reg_write(0, 9, 8'h27);
      check("R8 control keep-top pre", irq_ctrl, mic_m);
      reg_write(1, 9, 8'hE7);
      check("R8 control after full reset", irq_ctrl, 8'hE4);
      sweep("R8 after full reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule